// File: doc/BRIEF.md
# Multi-cycle instruction sequencer

This block is the control state machine of a small 16-bit processor with four general registers and three internal buses. The register file, the ALU, the program counter, the address and data registers and the memory all sit in a datapath outside this block. The sequencer watches the instruction register and the negative and zero flags, and on every cycle it drives the bus selects, the ALU operation code, the register-file port enables and the load, read, write, extend, address and clear strobes that move data through that datapath.

Every instruction starts with the same three fetch steps. An execute phase follows, and its length depends on the addressing modes of the two operands. It takes one step for a register or immediate operation or a branch, three steps when one operand sits in memory, and five steps when both do. The last execute step always asserts `clear`, and the machine then restarts at the first fetch step. The sequencer also builds the constant word that the instruction register puts onto a bus. That word is either a sign-extended literal or offset, or a short zero-extended absolute address.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high, every strobe output is 0: load_mar, inc_pc, mem_rd, mem_wr, load_mdr, load_ir, load_pc, regs_wr, load_status, extend, address, clear, rd1_en and rd2_en. After `rst` is released, `step` equals 1 (step T0) and `illegal` is 0. This holds even when reset arrives in the middle of an instruction.
- R2: Fetch step T0 asserts load_mar and inc_pc, with bus_b_sel=1 (PC) and alu_op=9 (pass B). Step T1 asserts mem_rd and load_mdr. Step T2 asserts load_ir with bus_b_sel=2 (MDR). No other strobe is active during fetch, whatever `ir` holds.
- R3: `step` is one-hot, and bit k marks step Tk. It advances by one bit each cycle. In the cycle after `clear` it returns to T0.
- R4: The instruction layout is opcode ir[15:13], source mode ir[12:11], source register ir[10:9], destination mode ir[8:7], destination register ir[6:5] and value ir[4:0]. The mode codes are 0 register, 1 indirect, 2 absolute and 3 immediate. A data opcode (0 to 6) with a register or immediate source and a register destination finishes in T3. T3 asserts rd2_en, load_status, regs_wr and clear, with bus_b_sel=0 and alu_op={0,opcode}. A register source sets rd1_en, rd1_idx=source register and bus_a_sel=0. An immediate source sets extend and bus_a_sel=1, and ir_word is ir[4:0] sign-extended.
- R5: An indirect or absolute source with a register destination takes T3 to T5. T3 loads the address register (load_mar). T4 asserts mem_rd and load_mdr. T5 computes with bus_a_sel=2 (MDR) and asserts rd2_en, load_status, regs_wr and clear.
- R6: A register or immediate source with an indirect or absolute destination takes T3 to T5. T3 computes into the data register (load_mdr and load_status, with no regs_wr). T4 loads the destination address with load_mar. T5 asserts mem_wr and clear.
- R7: When both operands are in memory, the instruction takes T3 to T7. The steps are source address, read, compute into the data register, destination address, and then write with clear at T7.
- R8: An address step for an indirect operand drives rd1_en, rd1_idx=that operand's register, bus_a_sel=0 and alu_op=8 (pass A). An address step for an absolute operand drives address, bus_b_sel=3 and alu_op=9. In that case ir_word holds {that operand's register field, ir[4:0]}, zero-extended to 7 bits.
- R9: Opcode 7 is a branch with condition ir[12:10], where 0 means always, 1 means Z=1, 2 means Z=0, 3 means N=1 and 4 means N=0. It finishes in T3 with extend, bus_a_sel=1, bus_b_sel=1 and alu_op=1 (add), and ir_word is ir[9:0] sign-extended. It asserts load_pc only when the condition holds.
- R10: A data opcode with destination mode 3, or a branch with condition 5 to 7, ends in T3 with clear as its only strobe. `illegal` rises in the next cycle and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 16 | Current instruction register contents |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| step | output | 8 | One-hot step state, bit k = Tk |
| bus_a_sel | output | 2 | Bus A source: 0 reg port 1, 1 instruction word, 2 MDR |
| bus_b_sel | output | 2 | Bus B source: 0 reg port 2, 1 PC, 2 MDR, 3 instruction word |
| alu_op | output | 4 | ALU operation: {0,opcode}, 1 add, 8 pass A, 9 pass B |
| rd1_en | output | 1 | Register read port 1 enable |
| rd1_idx | output | 2 | Register index for read port 1 |
| rd2_en | output | 1 | Register read port 2 enable (destination register) |
| regs_wr | output | 1 | Register file write to the destination register |
| load_status | output | 1 | Load N/Z flags from the ALU |
| load_mdr | output | 1 | Load memory data register |
| load_mar | output | 1 | Load memory address register |
| load_ir | output | 1 | Load instruction register |
| load_pc | output | 1 | Load program counter from ALU |
| inc_pc | output | 1 | Increment program counter |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| extend | output | 1 | Instruction word is sign-extended onto bus A |
| address | output | 1 | Instruction word is an absolute address on bus B |
| ir_word | output | 16 | Constant derived from the instruction |
| clear | output | 1 | Last step of the instruction; fetch restarts |
| illegal | output | 1 | Sticky illegal-instruction flag |

## Verification
The hardest path to reach from the ports is the eight-step memory-to-memory instruction. It must pass through two separate address steps, and each must pick the correct register field and word format. A second hard case is the sticky illegal flag, which must survive many later legal instructions. A directed sweep runs every pairing of source and destination mode, and every branch condition against all four flag combinations. Seeded random instruction words then mix these cases with illegal encodings. A reset is applied in the middle of a memory-to-memory instruction to show that the machine restarts cleanly and drops the flag.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned IW     = 16;
  localparam int unsigned STEP_N = 8;
  localparam int unsigned STEP_W = $clog2(STEP_N);

  localparam logic [2:0] OP_BRANCH  = 3'b111;
  localparam logic [3:0] ALU_ADD    = 4'h1;
  localparam logic [3:0] ALU_PASS_A = 4'h8;
  localparam logic [3:0] ALU_PASS_B = 4'h9;

  typedef enum logic [1:0] {
    AM_REG = 2'b00, AM_IND = 2'b01, AM_ABS = 2'b10, AM_IMM = 2'b11
  } amode_t;

  typedef enum logic [2:0] {
    BC_ALW = 3'd0, BC_ZS = 3'd1, BC_ZC = 3'd2, BC_NS = 3'd3, BC_NC = 3'd4
  } bcond_t;

  typedef enum logic [1:0] {
    BA_REG = 2'd0, BA_IRW = 2'd1, BA_MDR = 2'd2, BA_NONE = 2'd3
  } bus_a_t;

  typedef enum logic [1:0] {
    BB_REG = 2'd0, BB_PC = 2'd1, BB_MDR = 2'd2, BB_IRW = 2'd3
  } bus_b_t;

  typedef struct packed {
    logic load_mar;
    logic inc_pc;
    logic mem_rd;
    logic mem_wr;
    logic load_mdr;
    logic load_ir;
    logic load_pc;
    logic regs_wr;
    logic load_status;
    logic extend;
    logic address;
    logic clear;
    logic rd1_en;
    logic rd2_en;
  } strobe_t;

  typedef struct packed {
    logic [2:0] op;
    amode_t     sm;
    logic [1:0] rs;
    amode_t     dm;
    logic [1:0] rd;
    logic [4:0] val;
    logic [9:0] ofs;
    logic       is_br;
    logic       src_mem;
    logic       dst_mem;
    logic       illegal;
  } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [IW-1:0] ir,
  input  logic          flag_n,
  input  logic          flag_z,
  output dec_t          dec,
  output logic          br_take
);
  logic [2:0] cond;
  amode_t     sm_w;
  amode_t     dm_w;
  logic       br_w;

  assign cond = ir[12:10];
  assign sm_w = amode_t'(ir[12:11]);
  assign dm_w = amode_t'(ir[8:7]);
  assign br_w = (ir[15:13] == OP_BRANCH);

  always_comb begin
    dec.op      = ir[15:13];
    dec.sm      = sm_w;
    dec.rs      = ir[10:9];
    dec.dm      = dm_w;
    dec.rd      = ir[6:5];
    dec.val     = ir[4:0];
    dec.ofs     = ir[9:0];
    dec.is_br   = br_w;
    dec.src_mem = (sm_w == AM_IND) || (sm_w == AM_ABS);
    dec.dst_mem = (dm_w == AM_IND) || (dm_w == AM_ABS);
    dec.illegal = br_w ? (cond > BC_NC) : (dm_w == AM_IMM);
  end

  always_comb begin
    case (cond)
      BC_ALW:  br_take = 1'b1;
      BC_ZS:   br_take = flag_z;
      BC_ZC:   br_take = ~flag_z;
      BC_NS:   br_take = flag_n;
      BC_NC:   br_take = ~flag_n;
      default: br_take = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_steps.sv
module seq_steps #(
  parameter int unsigned N = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  output logic [SW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_ff @(posedge clk) begin
    if (rst || clear || (idx == SW'(N - 1))) idx <= '0;
    else                                      idx <= idx + SW'(1);
  end

  for (genvar g = 0; g < N; g++) begin : g_oh
    assign onehot[g] = (idx == SW'(g));
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [STEP_W-1:0] idx,
  input  dec_t              dec,
  input  logic              br_take,
  output strobe_t           stb,
  output bus_a_t            bus_a,
  output bus_b_t            bus_b,
  output logic [3:0]        alu,
  output logic [1:0]        rd1_idx,
  output logic [DW-1:0]     ir_word
);
  logic [STEP_W-1:0] calc_step;
  assign calc_step = dec.src_mem ? STEP_W'(5) : STEP_W'(3);

  always_comb begin
    stb     = '0;
    bus_a   = BA_NONE;
    bus_b   = BB_REG;
    alu     = 4'h0;
    rd1_idx = dec.rs;
    ir_word = '0;
    if (idx == STEP_W'(0)) begin
      stb.load_mar = 1'b1;
      stb.inc_pc   = 1'b1;
      bus_b        = BB_PC;
      alu          = ALU_PASS_B;
    end else if (idx == STEP_W'(1)) begin
      stb.mem_rd   = 1'b1;
      stb.load_mdr = 1'b1;
    end else if (idx == STEP_W'(2)) begin
      stb.load_ir = 1'b1;
      bus_b       = BB_MDR;
      alu         = ALU_PASS_B;
    end else if (dec.illegal) begin
      stb.clear = 1'b1;
    end else if (dec.is_br) begin
      stb.extend  = 1'b1;
      stb.load_pc = br_take;
      stb.clear   = 1'b1;
      bus_a       = BA_IRW;
      bus_b       = BB_PC;
      alu         = ALU_ADD;
      ir_word     = {{(DW-10){dec.ofs[9]}}, dec.ofs};
    end else if (dec.src_mem && idx == STEP_W'(3)) begin
      stb.load_mar = 1'b1;
      if (dec.sm == AM_IND) begin
        stb.rd1_en = 1'b1;
        rd1_idx    = dec.rs;
        bus_a      = BA_REG;
        alu        = ALU_PASS_A;
      end else begin
        stb.address = 1'b1;
        bus_b       = BB_IRW;
        alu         = ALU_PASS_B;
        ir_word     = {{(DW-7){1'b0}}, dec.rs, dec.val};
      end
    end else if (dec.src_mem && idx == STEP_W'(4)) begin
      stb.mem_rd   = 1'b1;
      stb.load_mdr = 1'b1;
    end else if (idx == calc_step) begin
      stb.rd2_en      = 1'b1;
      stb.load_status = 1'b1;
      bus_b           = BB_REG;
      alu             = {1'b0, dec.op};
      if (dec.src_mem) begin
        bus_a = BA_MDR;
      end else if (dec.sm == AM_IMM) begin
        bus_a      = BA_IRW;
        stb.extend = 1'b1;
        ir_word    = {{(DW-5){dec.val[4]}}, dec.val};
      end else begin
        bus_a      = BA_REG;
        stb.rd1_en = 1'b1;
        rd1_idx    = dec.rs;
      end
      if (dec.dst_mem) begin
        stb.load_mdr = 1'b1;
      end else begin
        stb.regs_wr = 1'b1;
        stb.clear   = 1'b1;
      end
    end else if (dec.dst_mem && idx == calc_step + STEP_W'(1)) begin
      stb.load_mar = 1'b1;
      if (dec.dm == AM_IND) begin
        stb.rd1_en = 1'b1;
        rd1_idx    = dec.rd;
        bus_a      = BA_REG;
        alu        = ALU_PASS_A;
      end else begin
        stb.address = 1'b1;
        bus_b       = BB_IRW;
        alu         = ALU_PASS_B;
        ir_word     = {{(DW-7){1'b0}}, dec.rd, dec.val};
      end
    end else if (dec.dst_mem && idx == calc_step + STEP_W'(2)) begin
      stb.mem_wr = 1'b1;
      stb.clear  = 1'b1;
    end else begin
      stb.clear = 1'b1;
    end
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     ir,
  input  logic              flag_n,
  input  logic              flag_z,
  output logic [STEP_N-1:0] step,
  output logic [1:0]        bus_a_sel,
  output logic [1:0]        bus_b_sel,
  output logic [3:0]        alu_op,
  output logic              rd1_en,
  output logic [1:0]        rd1_idx,
  output logic              rd2_en,
  output logic              regs_wr,
  output logic              load_status,
  output logic              load_mdr,
  output logic              load_mar,
  output logic              load_ir,
  output logic              load_pc,
  output logic              inc_pc,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              extend,
  output logic              address,
  output logic [DW-1:0]     ir_word,
  output logic              clear,
  output logic              illegal
);
  dec_t              dec;
  logic              br_take;
  logic [STEP_W-1:0] idx;
  strobe_t           stb;
  strobe_t           stb_g;
  bus_a_t            ba;
  bus_b_t            bb;
  logic              err_q;

  seq_decode u_dec (
    .ir      (ir),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .dec     (dec),
    .br_take (br_take)
  );

  seq_steps #(.N(STEP_N)) u_steps (
    .clk    (clk),
    .rst    (rst),
    .clear  (stb.clear),
    .idx    (idx),
    .onehot (step)
  );

  seq_ctrl #(.DW(DW)) u_ctrl (
    .idx     (idx),
    .dec     (dec),
    .br_take (br_take),
    .stb     (stb),
    .bus_a   (ba),
    .bus_b   (bb),
    .alu     (alu_op),
    .rd1_idx (rd1_idx),
    .ir_word (ir_word)
  );

  always_ff @(posedge clk) begin
    if (rst)                         err_q <= 1'b0;
    else if (stb.clear && dec.illegal) err_q <= 1'b1;
  end

  assign stb_g       = rst ? '0 : stb;
  assign bus_a_sel   = ba;
  assign bus_b_sel   = bb;
  assign load_mar    = stb_g.load_mar;
  assign inc_pc      = stb_g.inc_pc;
  assign mem_rd      = stb_g.mem_rd;
  assign mem_wr      = stb_g.mem_wr;
  assign load_mdr    = stb_g.load_mdr;
  assign load_ir     = stb_g.load_ir;
  assign load_pc     = stb_g.load_pc;
  assign regs_wr     = stb_g.regs_wr;
  assign load_status = stb_g.load_status;
  assign extend      = stb_g.extend;
  assign address     = stb_g.address;
  assign clear       = stb_g.clear;
  assign rd1_en      = stb_g.rd1_en;
  assign rd2_en      = stb_g.rd2_en;
  assign illegal     = err_q;
endmodule

// File: rtl/instr_sequencer_chk.sv
module instr_sequencer_chk
  import seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [STEP_N-1:0] step,
  input logic [3:0]        alu_op,
  input logic              load_mar,
  input logic              inc_pc,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              load_mdr,
  input logic              load_pc,
  input logic              regs_wr,
  input logic              load_status,
  input logic              clear,
  input logic              illegal
);
  // R1: quiet strobes during reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> !(load_mar || inc_pc || mem_rd || mem_wr || load_mdr ||
              load_pc || regs_wr || load_status || clear));

  a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1);

  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    clear |=> step[0]);

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    !clear |=> step == ($past(step) << 1));

  a_r2_fetch_entry: assert property (@(posedge clk) disable iff (rst)
    step[0] |-> (load_mar && inc_pc && alu_op == 4'h9));

  a_r5_read_after_addr: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !step[1]) |-> (load_mdr && $past(load_mar)));

  a_r6_write_ends: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (clear && !regs_wr));

  a_r9_pc_load: assert property (@(posedge clk) disable iff (rst)
    load_pc |-> (clear && step[3] && alu_op == 4'h1));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);
endmodule

bind instr_sequencer instr_sequencer_chk u_chk (.*);

// File: tb/sim_instr_sequencer.sv
module sim_instr_sequencer;
  localparam int B_MAR = 13, B_INC = 12, B_RD = 11, B_WR = 10, B_MDR = 9,
                 B_IR = 8, B_PC = 7, B_RW = 6, B_ST = 5, B_EXT = 4,
                 B_ADR = 3, B_CLR = 2, B_R1 = 1, B_R2 = 0;

  typedef struct packed {
    logic [13:0] s;
    logic        ca;  logic [1:0] a;
    logic        cb;  logic [1:0] b;
    logic        cl;  logic [3:0] alu;
    logic        cw;  logic [15:0] w;
    logic        ci;  logic [1:0] idx;
    logic        last;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ir = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0;
  logic [7:0]  step;
  logic [1:0]  bus_a_sel, bus_b_sel, rd1_idx;
  logic [3:0]  alu_op;
  logic [15:0] ir_word;
  logic rd1_en, rd2_en, regs_wr, load_status, load_mdr, load_mar, load_ir;
  logic load_pc, inc_pc, mem_rd, mem_wr, extend, address, clear, illegal;

  instr_sequencer #(.DW(16)) u0 (.*);

  always #10 clk = ~clk;

  wire [13:0] strb = {load_mar, inc_pc, mem_rd, mem_wr, load_mdr, load_ir, load_pc,
                      regs_wr, load_status, extend, address, clear, rd1_en, rd2_en};

  int   n_run = 0, n_fail = 0;
  logic exp_err = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (ir=%h step=%b)", req, act, expv, ir, step);
    end
  endtask

  function automatic bit is_bad(input logic [15:0] i);
    return (i[15:13] == 3'd7) ? (i[12:10] > 3'd4) : (i[8:7] == 2'd3);
  endfunction

  function automatic string req_of(input logic [15:0] i, input int k);
    bit sm, dm;
    sm = (i[12:11] == 2'd1) || (i[12:11] == 2'd2);
    dm = (i[8:7] == 2'd1) || (i[8:7] == 2'd2);
    if (k < 3) return "R2";
    if (is_bad(i)) return "R10";
    if (i[15:13] == 3'd7) return "R9";
    if (sm && dm) return "R7";
    if (sm) return "R5";
    if (dm) return "R6";
    return "R4";
  endfunction

  function automatic exp_t addr_step(input logic [1:0] mode, input logic [1:0] r,
                                     input logic [4:0] v);
    exp_t e = '0;
    e.s[B_MAR] = 1'b1;
    e.cl = 1'b1;
    if (mode == 2'd1) begin
      e.s[B_R1] = 1'b1; e.ca = 1'b1; e.a = 2'd0; e.ci = 1'b1; e.idx = r; e.alu = 4'h8;
    end else begin
      e.s[B_ADR] = 1'b1; e.cb = 1'b1; e.b = 2'd3; e.alu = 4'h9;
      e.cw = 1'b1; e.w = {9'd0, r, v};
    end
    return e;
  endfunction

  function automatic exp_t expect_at(input logic [15:0] i, input logic n,
                                     input logic z, input int k);
    exp_t e = '0;
    logic [2:0] op = i[15:13];
    logic [1:0] sm = i[12:11], dm = i[8:7];
    bit smem = (sm == 2'd1) || (sm == 2'd2);
    bit dmem = (dm == 2'd1) || (dm == 2'd2);
    int c = smem ? 5 : 3;
    bit take;
    if (k == 0) begin
      e.s[B_MAR] = 1; e.s[B_INC] = 1; e.cb = 1; e.b = 2'd1; e.cl = 1; e.alu = 4'h9;
    end else if (k == 1) begin
      e.s[B_RD] = 1; e.s[B_MDR] = 1;
    end else if (k == 2) begin
      e.s[B_IR] = 1; e.cb = 1; e.b = 2'd2;
    end else if (is_bad(i)) begin
      e.s[B_CLR] = 1; e.last = 1;
    end else if (op == 3'd7) begin
      case (i[12:10])
        3'd0: take = 1;  3'd1: take = z;  3'd2: take = !z;
        3'd3: take = n;  default: take = !n;
      endcase
      e.s[B_EXT] = 1; e.s[B_CLR] = 1; e.s[B_PC] = take;
      e.ca = 1; e.a = 2'd1; e.cb = 1; e.b = 2'd1; e.cl = 1; e.alu = 4'h1;
      e.cw = 1; e.w = {{6{i[9]}}, i[9:0]}; e.last = 1;
    end else if (smem && k == 3) begin
      e = addr_step(sm, i[10:9], i[4:0]);
    end else if (smem && k == 4) begin
      e.s[B_RD] = 1; e.s[B_MDR] = 1;
    end else if (k == c) begin
      e.s[B_ST] = 1; e.s[B_R2] = 1; e.cb = 1; e.b = 2'd0; e.cl = 1; e.alu = {1'b0, op};
      e.ca = 1;
      if (smem) e.a = 2'd2;
      else if (sm == 2'd3) begin
        e.a = 2'd1; e.s[B_EXT] = 1; e.cw = 1; e.w = {{11{i[4]}}, i[4:0]};
      end else begin
        e.a = 2'd0; e.s[B_R1] = 1; e.ci = 1; e.idx = i[10:9];
      end
      if (dmem) e.s[B_MDR] = 1;
      else begin e.s[B_RW] = 1; e.s[B_CLR] = 1; e.last = 1; end
    end else if (k == c + 1) begin
      e = addr_step(dm, i[6:5], i[4:0]);
    end else begin
      e.s[B_WR] = 1; e.s[B_CLR] = 1; e.last = 1;
    end
    return e;
  endfunction

  task automatic run_instr(input logic [15:0] i, input logic n, input logic z);
    exp_t  e;
    string tag;
    ir = i; flag_n = n; flag_z = z;
    for (int k = 0; k < 8; k++) begin
      #1;
      e   = expect_at(i, n, z, k);
      tag = req_of(i, k);
      chk(step == 8'(1 << k), "R3", step, 32'(1 << k));
      chk(strb == e.s, tag, strb, e.s);
      if (e.ca) chk(bus_a_sel == e.a, tag, bus_a_sel, e.a);
      if (e.cb) chk(bus_b_sel == e.b, tag, bus_b_sel, e.b);
      if (e.cl) chk(alu_op == e.alu, tag, alu_op, e.alu);
      if (e.ci) chk(rd1_idx == e.idx, "R8", rd1_idx, e.idx);
      if (e.cw) chk(ir_word == e.w, e.s[B_ADR] ? "R8" : tag, ir_word, e.w);
      if (e.last) break;
      @(negedge clk);
    end
    if (is_bad(i)) exp_err = 1'b1;
    @(negedge clk);
    #1;
    chk(step == 8'd1, "R3", step, 1);
    chk(illegal == exp_err, "R10", illegal, exp_err);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_0418);
    repeat (3) @(negedge clk);
    #1;
    chk(strb == '0, "R1", strb, 0);
    rst = 1'b0;
    #1;
    chk(step == 8'd1, "R1", step, 1);
    chk(illegal == 1'b0, "R1", illegal, 0);

    // every mode pairing (R4..R8, R10)
    for (int sm = 0; sm < 4; sm++)
      for (int dm = 0; dm < 4; dm++)
        run_instr({3'((sm * 4 + dm) % 7), 2'(sm), 2'(3 - sm), 2'(dm), 2'(dm),
                   5'(19 + sm * 3)}, 1'b0, 1'b0);

    // every branch condition against every flag pair (R9, R10)
    for (int cnd = 0; cnd < 8; cnd++)
      for (int f = 0; f < 4; f++)
        run_instr({3'd7, 3'(cnd), (f[0] ? 10'h3F5 : 10'h00A)}, f[1], f[0]);

    // seeded random instruction words
    for (int t = 0; t < 400; t++) begin
      r = $urandom;
      run_instr(r[15:0], r[16], r[17]);
    end

    // R1: reset in the middle of a memory-to-memory instruction
    ir = {3'd1, 2'd1, 2'd2, 2'd2, 2'd3, 5'd9};
    repeat (4) @(negedge clk);
    #1;
    chk(step == 8'b0001_0000, "R7", step, 8'h10);
    rst = 1'b1;
    #1;
    chk(strb == '0, "R1", strb, 0);
    @(negedge clk);
    rst = 1'b0;
    exp_err = 1'b0;
    #1;
    chk(step == 8'd1, "R1", step, 1);
    chk(illegal == 1'b0, "R1", illegal, 0);
    run_instr({3'd0, 2'd2, 2'd1, 2'd1, 2'd2, 5'd31}, 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule